// File: doc/BRIEF.md
# Multithreaded Context Switch and Trap Dispatch Controller

This controller sits beside a processor core that keeps several hardware thread contexts. An external memory and communications unit raises one of three trap request lines. One line reports a cache miss that must be served over the network. One reports a full/empty synchronization fault. The third covers every other asynchronous event. When the controller is idle and sees a request, it starts a fixed sequence of 14 cycles. In that sequence it records the PC and next-PC of the thread that was running and flushes the pipeline. It then points fetch at a dispatch vector chosen by the cause.

A remote miss or a synchronization fault moves execution to another hardware context, so the core does not stall. The next context is found by a round-robin search over the other contexts marked ready. A general trap dispatches on the same schedule but keeps the current context. Each dispatch entry holds 16 four-byte instructions, so a short handler can sit inline at its vector. The saved PC pair of any context can be read back through a read port for restore.

Top module: `ctx_switch_ctrl`

## Requirements
- R1: After reset, active_ctx is 0 and busy, flush and redirect_valid are all 0.
- R2: A trap request seen at a clock edge while busy is 0 is accepted. In the cycle after that edge, flush and busy are both 1. Flush stays 0 for every other cycle of the sequence.
- R3: The cycle after the accepting edge is cycle 1. redirect_valid is 1 only in cycle 14, and busy returns to 0 in cycle 15.
- R4: In cycle 14, redirect_addr = vec_base + (cause_code << 6). The cause codes are 0 for remote miss, 1 for sync fault and 2 for general trap.
- R5: When several requests arrive together, sync fault (trap_sync) wins over remote miss (trap_miss), and remote miss wins over general trap (trap_other).
- R6: On a remote miss or a sync fault, the new context is the first context marked in ctx_ready at the accepting edge. The search runs from active_ctx+1 upward, wraps modulo 4 and skips the current context. If no other context is ready, the context does not change. active_ctx keeps its old value through cycle 13 and shows the new value from cycle 14.
- R7: A general trap that wins arbitration runs the same sequence and leaves active_ctx unchanged.
- R8: At the accepting edge, cur_pc and cur_npc are stored in the save slot of the context that was running. Driving rd_ctx with that index shows them on rd_pc and rd_npc from cycle 1 onward.
- R9: While busy is 1, the trap inputs, cur_pc, cur_npc and ctx_ready are ignored, so cause, target context and save slots keep their values. A trap held through cycle 14 is sampled at the edge that ends cycle 15, and flush rises in cycle 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_miss | input | 1 | Remote cache miss request |
| trap_sync | input | 1 | Full/empty synchronization fault request |
| trap_other | input | 1 | General asynchronous trap request |
| cur_pc | input | 32 | PC of the running thread |
| cur_npc | input | 32 | Next-PC of the running thread |
| ctx_ready | input | 4 | One bit per context, set when that context can run |
| vec_base | input | 32 | Base address of the dispatch table |
| rd_ctx | input | 2 | Context whose save slot is read |
| active_ctx | output | 2 | Index of the running context |
| flush | output | 1 | Pipeline flush, first cycle of the sequence |
| busy | output | 1 | Switch sequence in progress |
| redirect_valid | output | 1 | Fetch redirect strobe |
| redirect_addr | output | 32 | Fetch redirect address |
| rd_pc | output | 32 | Saved PC of context rd_ctx |
| rd_npc | output | 32 | Saved next-PC of context rd_ctx |

## Verification
A wrong cycle counter shows up within a single sequence: the redirect strobe comes early or late, or busy stays high one cycle too long. A corrupted latched cause or a wrong arbitration result shows in cycle 14 as a redirect address off by a multiple of 64. A wrong round-robin pointer shows in active_ctx at that redirect. Its effect then builds up over later switches, because each search starts from the context the previous switch left running. A save slot that captures at the wrong time, or that is overwritten during the busy window, is seen on the read port one cycle after the sequence ends.

// File: rtl/ctxsw_pkg.sv
package ctxsw_pkg;

  typedef enum logic [1:0] {
    CAUSE_MISS  = 2'd0,
    CAUSE_SYNC  = 2'd1,
    CAUSE_OTHER = 2'd2
  } cause_e;

  // Dispatch address: each cause owns one entry of (1 << shift) bytes.
  function automatic logic [31:0] vector_addr(input logic [31:0] base,
                                              input cause_e cause,
                                              input int shift);
    return base + ({30'd0, cause} << shift);
  endfunction

  // Round-robin search over the other contexts, starting after cur.
  function automatic int next_ctx(input int cur, input logic [31:0] ready,
                                  input int n);
    int pick;
    pick = cur;
    for (int step = n - 1; step >= 1; step--) begin
      if (ready[(cur + step) % n]) pick = (cur + step) % n;
    end
    return pick;
  endfunction

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import ctxsw_pkg::*;
(
  input  logic   req_miss,
  input  logic   req_sync,
  input  logic   req_other,
  output logic   any_req,
  output logic   do_switch,
  output cause_e cause
);

  logic [2:0] grant;

  always_comb begin
    grant = 3'b000;
    if (req_sync)       grant[1] = 1'b1;
    else if (req_miss)  grant[0] = 1'b1;
    else if (req_other) grant[2] = 1'b1;
  end

  always_comb begin
    cause = CAUSE_MISS;
    if (grant[1])      cause = CAUSE_SYNC;
    else if (grant[2]) cause = CAUSE_OTHER;
  end

  assign any_req   = |grant;
  assign do_switch = grant[0] | grant[1];

  always_comb begin
    a_grant_onehot_r5: assert ($onehot0(grant));
  end

endmodule

// File: rtl/ctx_save_bank.sv
module ctx_save_bank #(
  parameter int NCTX = 4,
  parameter int XLEN = 32,
  localparam int CW = $clog2(NCTX)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CW-1:0]   wr_ctx,
  input  logic [XLEN-1:0] wr_pc,
  input  logic [XLEN-1:0] wr_npc,
  input  logic [CW-1:0]   rd_ctx,
  output logic [XLEN-1:0] rd_pc,
  output logic [XLEN-1:0] rd_npc
);

  logic [XLEN-1:0] pc_q  [NCTX];
  logic [XLEN-1:0] npc_q [NCTX];

  for (genvar g = 0; g < NCTX; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pc_q[g]  <= '0;
        npc_q[g] <= '0;
      end else if (wr_en && (wr_ctx == CW'(g))) begin
        pc_q[g]  <= wr_pc;
        npc_q[g] <= wr_npc;
      end
    end
  end

  assign rd_pc  = pc_q[rd_ctx];
  assign rd_npc = npc_q[rd_ctx];

  p_save_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (pc_q[$past(wr_ctx)] == $past(wr_pc)) &&
              (npc_q[$past(wr_ctx)] == $past(wr_npc)));

endmodule

// File: rtl/switch_sequencer.sv
module switch_sequencer
  import ctxsw_pkg::*;
#(
  parameter int NCTX    = 4,
  parameter int SEQ_LEN = 14,
  localparam int CW   = $clog2(NCTX),
  localparam int CNTW = $clog2(SEQ_LEN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            any_req,
  input  logic            do_switch,
  input  cause_e          req_cause,
  input  logic [NCTX-1:0] ctx_ready,
  output logic            accept,
  output logic            seq_first,
  output logic            seq_last,
  output logic            seq_busy,
  output cause_e          cause_q,
  output logic [CW-1:0]   active_q
);

  logic [CNTW-1:0] cnt_q;
  logic [CW-1:0]   target_q;
  logic [CW-1:0]   rr_pick;

  assign seq_busy  = (cnt_q != '0);
  assign seq_first = (cnt_q == CNTW'(1));
  assign seq_last  = (cnt_q == CNTW'(SEQ_LEN));
  assign accept    = !seq_busy && any_req;
  assign rr_pick   = CW'(next_ctx(int'(active_q), 32'(ctx_ready), NCTX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      cause_q  <= CAUSE_MISS;
      target_q <= '0;
      active_q <= '0;
    end else if (accept) begin
      cnt_q    <= CNTW'(1);
      cause_q  <= req_cause;
      target_q <= do_switch ? rr_pick : active_q;
    end else if (seq_busy) begin
      cnt_q <= seq_last ? '0 : cnt_q + CNTW'(1);
      if (cnt_q == CNTW'(SEQ_LEN - 1)) active_q <= target_q;
    end
  end

  p_cause_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && !seq_last) |=> $stable(cause_q) && $stable(target_q));

  p_other_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !do_switch) |=> (target_q == active_q));

  p_pick_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && do_switch && (rr_pick != active_q)) |-> ctx_ready[rr_pick]);

endmodule

// File: rtl/ctx_switch_ctrl.sv
module ctx_switch_ctrl
  import ctxsw_pkg::*;
#(
  parameter int NCTX        = 4,
  parameter int XLEN        = 32,
  parameter int SEQ_LEN     = 14,
  parameter int ENTRY_INSNS = 16,
  localparam int CW         = $clog2(NCTX),
  localparam int VEC_SHIFT  = $clog2(ENTRY_INSNS * 4)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_miss,
  input  logic            trap_sync,
  input  logic            trap_other,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] cur_npc,
  input  logic [NCTX-1:0] ctx_ready,
  input  logic [31:0]     vec_base,
  input  logic [CW-1:0]   rd_ctx,
  output logic [CW-1:0]   active_ctx,
  output logic            flush,
  output logic            busy,
  output logic            redirect_valid,
  output logic [31:0]     redirect_addr,
  output logic [XLEN-1:0] rd_pc,
  output logic [XLEN-1:0] rd_npc
);

  logic   any_req, do_switch, accept, seq_first, seq_last;
  cause_e req_cause, cause_q;

  trap_arbiter u_arb (
    .req_miss  (trap_miss),
    .req_sync  (trap_sync),
    .req_other (trap_other),
    .any_req   (any_req),
    .do_switch (do_switch),
    .cause     (req_cause)
  );

  switch_sequencer #(.NCTX(NCTX), .SEQ_LEN(SEQ_LEN)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .any_req   (any_req),
    .do_switch (do_switch),
    .req_cause (req_cause),
    .ctx_ready (ctx_ready),
    .accept    (accept),
    .seq_first (seq_first),
    .seq_last  (seq_last),
    .seq_busy  (busy),
    .cause_q   (cause_q),
    .active_q  (active_ctx)
  );

  ctx_save_bank #(.NCTX(NCTX), .XLEN(XLEN)) u_save (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (accept),
    .wr_ctx (active_ctx),
    .wr_pc  (cur_pc),
    .wr_npc (cur_npc),
    .rd_ctx (rd_ctx),
    .rd_pc  (rd_pc),
    .rd_npc (rd_npc)
  );

  assign flush          = seq_first;
  assign redirect_valid = seq_last;
  assign redirect_addr  = seq_last ? vector_addr(vec_base, cause_q, VEC_SHIFT) : '0;

  p_flush_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> flush && busy);

  p_flush_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);

  p_redirect_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !busy && !redirect_valid);

  p_ctx_moves_at_redirect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active_ctx != $past(active_ctx)) |-> redirect_valid);

  p_vector_in_table_r4: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (((redirect_addr - vec_base) >> VEC_SHIFT) <= 32'd2));

endmodule

// File: tb/ctx_switch_ctrl_bench.sv
module ctx_switch_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_miss = 1'b0, trap_sync = 1'b0, trap_other = 1'b0;
  logic [31:0] cur_pc = '0, cur_npc = '0;
  logic [3:0]  ctx_ready = '0;
  logic [31:0] vec_base = 32'h0000_4000;
  logic [1:0]  rd_ctx = '0;
  logic [1:0]  active_ctx;
  logic        flush, busy, redirect_valid;
  logic [31:0] redirect_addr, rd_pc, rd_npc;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  int cur = 0;
  int serial = 0;

  always #4 clk = ~clk;

  ctx_switch_ctrl u_ctx_switch_ctrl (
    .clk(clk), .rst_n(rst_n), .trap_miss(trap_miss), .trap_sync(trap_sync),
    .trap_other(trap_other), .cur_pc(cur_pc), .cur_npc(cur_npc),
    .ctx_ready(ctx_ready), .vec_base(vec_base), .rd_ctx(rd_ctx),
    .active_ctx(active_ctx), .flush(flush), .busy(busy),
    .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
    .rd_pc(rd_pc), .rd_npc(rd_npc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int model_next(input int old, input logic [3:0] rdy);
    int res;
    bit found;
    res = old;
    found = 1'b0;
    for (int k = 1; k < 4; k++) begin
      if (!found && rdy[(old + k) & 3]) begin
        res = (old + k) & 3;
        found = 1'b1;
      end
    end
    return res;
  endfunction

  task automatic run_seq(input logic m, input logic s, input logic o, input logic [3:0] rdy);
    int code;
    int expn;
    int old;
    logic [31:0] pc;
    code = s ? 1 : (m ? 0 : 2);
    old  = cur;
    expn = (s || m) ? model_next(old, rdy) : old;
    serial++;
    pc = 32'h0001_0000 + serial * 16;
    @(negedge clk);
    trap_miss = m; trap_sync = s; trap_other = o;
    cur_pc = pc; cur_npc = pc + 4; ctx_ready = rdy;
    @(negedge clk);
    check("R2 flush cycle1", {31'd0, flush}, 32'd1);
    check("R2 busy cycle1", {31'd0, busy}, 32'd1);
    // R9: disturb every input during the busy window
    trap_miss = 1'b1; trap_sync = 1'b1; trap_other = 1'b1;
    cur_pc = 32'hDEAD_0000; cur_npc = 32'hDEAD_0004; ctx_ready = ~rdy;
    for (int c = 2; c <= 13; c++) begin
      @(negedge clk);
      check("R2 flush low", {31'd0, flush}, 32'd0);
      check("R3 no early redirect", {31'd0, redirect_valid}, 32'd0);
      check("R6 ctx held", {30'd0, active_ctx}, 32'(old));
      if (c == 12) begin
        trap_miss = 1'b0; trap_sync = 1'b0; trap_other = 1'b0;
      end
    end
    @(negedge clk);
    check("R3 redirect cycle14", {31'd0, redirect_valid}, 32'd1);
    check("R4 R5 vector", redirect_addr, vec_base + 32'(code) * 32'd64);
    if (s || m) check("R6 next ctx", {30'd0, active_ctx}, 32'(expn));
    else        check("R7 ctx kept", {30'd0, active_ctx}, 32'(expn));
    @(negedge clk);
    check("R3 R9 idle cycle15", {31'd0, busy}, 32'd0);
    rd_ctx = 2'(old);
    #1;
    check("R8 saved pc", rd_pc, pc);
    check("R8 saved npc", rd_npc, pc + 4);
    cur = expn;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 flush", {31'd0, flush}, 32'd0);
    check("R1 redirect", {31'd0, redirect_valid}, 32'd0);
    check("R1 ctx", {30'd0, active_ctx}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", {31'd0, busy}, 32'd0);

    for (int combo = 1; combo < 8; combo++) begin
      for (int r = 0; r < 16; r++) begin
        run_seq(combo[0], combo[1], combo[2], 4'(r));
      end
    end

    vec_base = 32'h8000_1000;
    run_seq(1'b1, 1'b0, 1'b0, 4'hF);
    run_seq(1'b0, 1'b0, 1'b1, 4'hF);

    // R9: a trap held through cycle 14 is sampled again after completion
    @(negedge clk);
    trap_other = 1'b1;
    @(negedge clk);
    check("R9 first accept", {31'd0, flush}, 32'd1);
    repeat (13) @(negedge clk);
    check("R9 redirect held trap", {31'd0, redirect_valid}, 32'd1);
    @(negedge clk);
    check("R9 cycle15 idle", {31'd0, busy}, 32'd0);
    @(negedge clk);
    check("R9 resampled flush", {31'd0, flush}, 32'd1);
    trap_other = 1'b0;
    repeat (14) @(negedge clk);
    check("R9 second done", {31'd0, busy}, 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule